// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits each, where `WIDTH` is even. It gives a signed product of `2*WIDTH` bits. It works over several cycles and uses one shared adder. An accumulator holds the running partial sum. A multiplier register retires two bits per step, and a multiplicand register stays unchanged for the whole operation.

On each step, the two low bits of the multiplier register and the bit retired just before them are recoded into one multiple of the multiplicand. That multiple is zero, plus or minus one times the multiplicand, or plus or minus two times it. The multiple is added to the accumulator. The combined accumulator/multiplier pair then shifts right by two places and keeps its sign. After `WIDTH/2` steps, the product sits in the low `2*WIDTH` bits of the pair.

The surrounding logic pulses `start_i` while the block is idle. It then waits for the one-cycle `done_o` strobe and reads `product_o`. The reset input is expected to be asserted asynchronously and released in step with `clk` by the reset tree upstream.

Top module: `booth4_mul`

## Requirements
- R1: While `rst_n` is low and after its release, with no start yet given, `busy_o` is 0, `done_o` is 0 and `product_o` is all zeros.
- R2: When `start_i` is high at a rising edge while `busy_o` is low, both operands are captured at that edge and `busy_o` is high from that edge on.
- R3: `busy_o` stays high for exactly `WIDTH/2` cycles. `done_o` is high for exactly one cycle, the cycle right after the last step. In that cycle `busy_o` is low.
- R4: When `done_o` is high, `product_o` equals the signed product of the two captured operands as a `2*WIDTH`-bit two's-complement value. This includes both operands at the most negative value.
- R5: Each step recodes the group {bit1, bit0, previously retired bit} as follows. 000 and 111 add nothing. 001 and 010 add +b. 011 adds +2b. 100 adds -2b. 101 and 110 add -b. On the first step the previously retired bit is taken as 0. This is checked through R4 across every multiplier value.
- R6: A `start_i` pulse while `busy_o` is high is ignored. The running operation keeps its operands and its timing.
- R7: While the block is idle, `product_o` keeps its value until the next accepted start, whatever `start_i` (held low) and the operand inputs do.
- R8: A start given in the same cycle that `done_o` is high is accepted. The new result follows with the same timing as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| start_i | input | 1 | Begin a multiplication when idle |
| mcand_i | input | WIDTH | Multiplicand, two's complement |
| mplier_i | input | WIDTH | Multiplier, two's complement |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle strobe: product valid |
| product_o | output | 2*WIDTH | Signed product |

## Verification
A wrong recoding or a wrong accumulator shift corrupts the product. The error shows up only at the `done_o` strobe, `WIDTH/2 + 1` cycles after the start. A sweep over every multiplier value, with several multiplicands, therefore exercises every recoding group at every step position. A miscounted step counter moves the `done_o` strobe, so each result is also checked against the exact cycle in which it is expected. A multiplicand register that is wrongly reloaded during a run appears as a product built from the ignored operands.

// File: rtl/booth4_pkg.sv
package booth4_pkg;
  // Multiple of the multiplicand chosen by one recoding group.
  typedef enum logic [2:0] {
    SEL_ZERO = 3'd0,
    SEL_POS1 = 3'd1,
    SEL_POS2 = 3'd2,
    SEL_NEG1 = 3'd3,
    SEL_NEG2 = 3'd4
  } booth_sel_e;
endpackage

// File: rtl/booth4_recoder.sv
module booth4_recoder
  import booth4_pkg::*;
(
  input  logic [2:0] grp_i,   // {bit1, bit0, previously retired bit}
  output booth_sel_e sel_o
);
  always_comb begin
    unique case (grp_i)
      3'b001, 3'b010: sel_o = SEL_POS1;
      3'b011:         sel_o = SEL_POS2;
      3'b100:         sel_o = SEL_NEG2;
      3'b101, 3'b110: sel_o = SEL_NEG1;
      default:        sel_o = SEL_ZERO;   // 000, 111
    endcase
  end
endmodule

// File: rtl/booth4_multiple.sv
module booth4_multiple
  import booth4_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int PW = WIDTH + 2
) (
  input  logic [WIDTH-1:0] mcand_i,
  input  booth_sel_e       sel_i,
  output logic [PW-1:0]    addend_o,
  output logic             cin_o
);
  logic [PW-1:0] one_x;
  logic [PW-1:0] two_x;

  always_comb begin
    one_x = {{2{mcand_i[WIDTH-1]}}, mcand_i};
    two_x = {one_x[PW-2:0], 1'b0};
    unique case (sel_i)
      SEL_POS1: begin addend_o = one_x;  cin_o = 1'b0; end
      SEL_POS2: begin addend_o = two_x;  cin_o = 1'b0; end
      SEL_NEG1: begin addend_o = ~one_x; cin_o = 1'b1; end
      SEL_NEG2: begin addend_o = ~two_x; cin_o = 1'b1; end
      default:  begin addend_o = '0;     cin_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/booth4_adder.sv
module booth4_adder #(
  parameter int PW = 10
) (
  input  logic [PW-1:0] a_i,
  input  logic [PW-1:0] b_i,
  input  logic          cin_i,
  output logic [PW-1:0] sum_o
);
  always_comb begin
    sum_o = a_i + b_i + {{(PW-1){1'b0}}, cin_i};
  end
endmodule

// File: rtl/booth4_mul.sv
module booth4_mul
  import booth4_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int PW    = WIDTH + 2;
  localparam int STEPS = WIDTH / 2;
  localparam int CW    = $clog2(STEPS + 1);

  // State registers
  logic [PW-1:0]    acc_q,   acc_d;
  logic [WIDTH-1:0] mpl_q,   mpl_d;
  logic [WIDTH-1:0] mcd_q,   mcd_d;
  logic             prev_q,  prev_d;
  logic [CW-1:0]    cnt_q,   cnt_d;
  logic             busy_q,  busy_d;
  logic             done_q,  done_d;

  // Datapath
  booth_sel_e    sel;
  logic [PW-1:0] addend;
  logic          cin;
  logic [PW-1:0] sum;
  logic          accept;
  logic          step_en;
  logic          last_step;

  booth4_recoder u_rec (
    .grp_i ({mpl_q[1:0], prev_q}),
    .sel_o (sel)
  );

  booth4_multiple #(.WIDTH(WIDTH)) u_mult (
    .mcand_i  (mcd_q),
    .sel_i    (sel),
    .addend_o (addend),
    .cin_o    (cin)
  );

  booth4_adder #(.PW(PW)) u_add (
    .a_i   (acc_q),
    .b_i   (addend),
    .cin_i (cin),
    .sum_o (sum)
  );

  // Next-state logic
  always_comb begin
    accept    = start_i && !busy_q;
    step_en   = busy_q;
    last_step = busy_q && (cnt_q == CW'(1));

    acc_d  = acc_q;
    mpl_d  = mpl_q;
    mcd_d  = mcd_q;
    prev_d = prev_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;

    if (accept) begin
      acc_d  = '0;
      mpl_d  = mplier_i;
      mcd_d  = mcand_i;
      prev_d = 1'b0;
      cnt_d  = CW'(STEPS);
      busy_d = 1'b1;
    end else if (step_en) begin
      // arithmetic right shift of the pair {sum, mpl} by two
      acc_d  = {{2{sum[PW-1]}}, sum[PW-1:2]};
      mpl_d  = {sum[1:0], mpl_q[WIDTH-1:2]};
      prev_d = mpl_q[1];
      cnt_d  = cnt_q - CW'(1);
      if (last_step) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mpl_q  <= '0;
      mcd_q  <= '0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      mpl_q  <= mpl_d;
      mcd_q  <= mcd_d;
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign product_o = {acc_q[WIDTH-1:0], mpl_q};

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R6
  mcand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(mcd_q));

  // R7
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(product_o));

  // R3
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt_q == CW'(1)) |=> (done_o && !busy_o));
endmodule

// File: tb/booth4_mul_tb.sv
module booth4_mul_tb_top;
  localparam int W     = 8;
  localparam int STEPS = W / 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start_i = 1'b0;
  logic [W-1:0]   mcand_i = '0;
  logic [W-1:0]   mplier_i = '0;
  logic           busy_o;
  logic           done_o;
  logic [2*W-1:0] product_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 1'b0;
  logic [2*W-1:0] last_prod = '0;

  logic [2*W-1:0] exp_q[$];
  int             when_q[$];

  booth4_mul #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
  );

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] ea, eb;
    ea = $signed(a);
    eb = $signed(b);
    return ea * eb;
  endfunction

  // Driver: issue one multiplication, push its expectation.
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
    while (busy_o) @(negedge clk);
    start_i  = 1'b1;
    mcand_i  = a;
    mplier_i = b;
    exp_q.push_back(ref_mul(a, b));
    when_q.push_back(cyc + 1 + STEPS);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R2 busy after start", busy_o, 1);
  endtask

  task automatic drain();
    while (busy_o || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compare results as they appear.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected done", 1, 0);
      end else begin
        logic [2*W-1:0] e;
        int t;
        e = exp_q.pop_front();
        t = when_q.pop_front();
        check(product_o === e, "R4/R5 product", product_o, e);
        check(cyc == t, "R3 done timing", cyc, t);
        check(busy_o === 1'b0, "R3 busy low at done", busy_o, 0);
        last_prod = e;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0 && product_o === '0, "R1 in reset",
          {busy_o, done_o, product_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0 && product_o === '0, "R1 after reset",
          {busy_o, done_o, product_o}, 0);

    // R4: corner operands
    issue(8'h80, 8'h80);
    issue(8'h80, 8'h7F);
    issue(8'h7F, 8'h7F);
    issue(8'hFF, 8'h80);
    issue(8'h00, 8'h55);
    issue(8'h01, 8'hFF);
    drain();

    // R5: every multiplier value with several multiplicands
    foreach (mcand_i[i]) begin end
    for (int m = 0; m < 4; m++) begin
      logic [W-1:0] a;
      a = (m == 0) ? 8'h80 : (m == 1) ? 8'h7F : (m == 2) ? 8'hB3 : 8'h05;
      for (int b = 0; b < 256; b++) issue(a, 8'(b));
    end
    drain();

    // R8: back-to-back starts on the done cycle (issue waits only for !busy)
    for (int k = 0; k < 50; k++) issue(8'($urandom), 8'($urandom));
    drain();

    // R6: start while busy is ignored
    issue(8'h93, 8'h6C);
    start_i  = 1'b1;
    mcand_i  = 8'h11;
    mplier_i = 8'h22;
    repeat (2) @(negedge clk);
    start_i = 1'b0;
    drain();
    check(last_prod === ref_mul(8'h93, 8'h6C), "R6 ignored start", last_prod, ref_mul(8'h93, 8'h6C));
    check(busy_o === 1'b0, "R6 no extra run", busy_o, 0);

    // R7: idle product hold with changing operand inputs
    for (int k = 0; k < 4; k++) begin
      mcand_i  = 8'($urandom);
      mplier_i = 8'($urandom);
      @(negedge clk);
      check(product_o === last_prod && busy_o === 1'b0, "R7 product held", product_o, last_prod);
    end

    check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
    finish_run();
  end
endmodule